// File: doc/BRIEF.md
# SD Host Wrapper Register Bank

This block is the register front end placed ahead of one or two SD host slot controllers. It answers a 4 KiB, word-access-only register window. The lowest 256 bytes hold the wrapper's own registers, and each slot's own register window lies in a 256-byte page above them. The wrapper keeps these global words: a controller-information word, a debounce word, a bus word, a write-protect polarity word, a card-detect word and a live interrupt-status word. For each slot it also keeps a writable 64-bit capability shadow and a 32-bit maximum-current shadow. The capability shadow is seen as two independent 32-bit halves.

Accesses that land in a slot page are not stored locally. They are steered to that slot through a one-hot select, a page offset, a write strobe, write data and a returned read word. The slots' interrupt levels are sampled into the status word, and their OR drives a single interrupt output.

Reads return data combinationally from the address. A write commits on the rising clock edge where the write enable is high.

Top module: `sdw_regbank`

## Requirements
- R1: After reset, offset 0x00 reads 0x00010000, with 0x00020000 also set when two slots are configured (so 0x00030000 by default). Offset 0x04 reads 0x00000005. Offsets 0x08, 0xEC, 0xF0 and 0xFC read 0, and the interrupt output is low.
- R2: Bit 0 of offset 0x00 always reads 0 after any write. Bits 31:1 hold the value written.
- R3: Wrapper offsets without a special meaning, including 0x08, 0xEC, 0xF0 and 0x40, read back the last 32-bit value written to them.
- R4: Slot 0's capability halves sit at 0x10 (bits 31:0) and 0x14 (bits 63:32), and slot 1's sit at 0x20 and 0x24. Both reset to the CAP_RESET parameter, which defaults to 0x00000007_01F80080.
- R5: A write to one capability half replaces only that half and leaves the other half of the same slot, and the other slot, unchanged.
- R6: Maximum-current shadows sit at 0x18 (slot 0) and 0x28 (slot 1) and reset to 0. A write to either one changes only that slot's value.
- R7: Bit n of offset 0xFC equals slot n's interrupt level as sampled at the previous rising edge. Writes to 0xFC have no effect.
- R8: The interrupt output is high exactly when at least one bit of the status word is set.
- R9: An aligned address in page i+1, that is (i+1)*0x100 to (i+1)*0x100+0xFF, raises bit i of the one-hot slot select. The offset output then carries address bits 7:0, the write strobe follows the write enable, the write data passes through, and the read data returns slot i's read word. Such writes leave the wrapper registers unchanged.
- R10: Aligned addresses at or above (NUM_SLOTS+1)*0x100 read 0, select no slot, and leave all state unchanged on a write.
- R11: Addresses with bits 1:0 not 00 read 0, select no slot, and leave all state unchanged on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_we | input | 1 | Write enable, committed on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| slot_irq | input | 2 | Interrupt level from each slot |
| irq_out | output | 1 | Merged interrupt |
| slot_sel | output | 2 | One-hot slot page select |
| slot_we | output | 1 | Write strobe to the selected slot |
| slot_off | output | 8 | Byte offset inside the slot page |
| slot_wdata | output | 32 | Write data to the slot |
| slot_rdata | input | 64 | Read words of the slots, slot i at bits 32i+31:32i |

## Verification
The bench targets the self-clearing bit 0 of the information word. A design that stored it would read back 0xFFFFFFFF after an all-ones write. It also writes one capability half and reads the other, which catches a full 64-bit overwrite. It also writes slot 1's current shadow, which catches a design that draws on slot 0's value. For interrupts, the bench lowers one slot while the other still holds its level; a design that lowered the output on any falling line would drop a pending request. Stores into slot pages, past the last page and at unaligned addresses are each followed by a readback of a wrapper word that such a design would have corrupted.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

   localparam int IDX_INFO        = 0;
   localparam int IDX_DEBOUNCE    = 1;
   localparam int IDX_SHADOW_BASE = 4;
   localparam int SHADOW_STRIDE   = 4;
   localparam int SHADOW_FIELDS   = 3;
   localparam int PRESENT_LSB     = 16;
   localparam logic [31:0] DEBOUNCE_RST = 32'h0000_0005;

   typedef struct packed {
      logic aligned;
      logic in_wrap;
      logic in_slot;
   } sdw_dec_t;

endpackage

// File: rtl/sdw_addr_dec.sv
module sdw_addr_dec
   import sdw_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int WIN_W     = 8,
   parameter int NUM_SLOTS = 2
) (
   input  logic [ADDR_W-1:0]    addr,
   output sdw_dec_t             dec,
   output logic [NUM_SLOTS-1:0] sel
);
   localparam int PAGE_W = ADDR_W - WIN_W;

   logic [PAGE_W-1:0] page;
   logic              aligned;

   assign page    = addr[ADDR_W-1:WIN_W];
   assign aligned = (addr[1:0] == 2'b00);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_page
      assign sel[i] = aligned && (page == PAGE_W'(i + 1));
   end

   assign dec.aligned = aligned;
   assign dec.in_wrap = aligned && (page == '0);
   assign dec.in_slot = |sel;

endmodule

// File: rtl/sdw_gp_file.sv
module sdw_gp_file
   import sdw_pkg::*;
#(
   parameter int          IDX_W    = 6,
   parameter logic [31:0] INFO_RST = 32'h0003_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd
);
   localparam int WORDS = 2 ** IDX_W;

   function automatic logic [31:0] rst_val(input int k);
      if (k == IDX_INFO)     return INFO_RST;
      if (k == IDX_DEBOUNCE) return DEBOUNCE_RST;
      return 32'h0;
   endfunction

   logic [31:0] mem [WORDS];

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[k] <= rst_val(k);
         else if (we && (idx == IDX_W'(k)))
            mem[k] <= wdata;
      end
   end

   assign rd = mem[idx];

endmodule

// File: rtl/sdw_cap_shadow.sv
module sdw_cap_shadow #(
   parameter logic [63:0] CAP_RST = 64'h0000_0007_01F8_0080,
   parameter logic [31:0] MC_RST  = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we_lo,
   input  logic        we_hi,
   input  logic        we_mc,
   input  logic [31:0] wdata,
   output logic [63:0] cap,
   output logic [31:0] mc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap <= CAP_RST;
         mc  <= MC_RST;
      end else begin
         if (we_lo) cap[31:0]  <= wdata;
         if (we_hi) cap[63:32] <= wdata;
         if (we_mc) mc         <= wdata;
      end
   end

endmodule

// File: rtl/sdw_irq_merge.sv
module sdw_irq_merge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] stat,
   output logic         any
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= lvl;
   end

   assign any = |stat;

endmodule

// File: rtl/sdw_regbank.sv
module sdw_regbank
   import sdw_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          WIN_W     = 8,
   parameter int          NUM_SLOTS = 2,
   parameter logic [63:0] CAP_RESET = 64'h0000_0007_01F8_0080,
   parameter logic [31:0] MC_RESET  = 32'h0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_we,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic [NUM_SLOTS-1:0]    slot_irq,
   output logic                    irq_out,
   output logic [NUM_SLOTS-1:0]    slot_sel,
   output logic                    slot_we,
   output logic [WIN_W-1:0]        slot_off,
   output logic [31:0]             slot_wdata,
   input  logic [NUM_SLOTS*32-1:0] slot_rdata
);
   localparam int IDX_W   = WIN_W - 2;
   localparam int IDX_IRQ = (2 ** IDX_W) - 1;
   localparam logic [31:0] INFO_RST =
      (32'h1 << PRESENT_LSB) | ((NUM_SLOTS == 2) ? (32'h1 << (PRESENT_LSB + 1)) : 32'h0);

   if (NUM_SLOTS < 1 || NUM_SLOTS > 2) begin : g_bad_slots
      $error("sdw_regbank: NUM_SLOTS must be 1 or 2");
   end
   if (ADDR_W <= WIN_W || (NUM_SLOTS + 1) > (2 ** (ADDR_W - WIN_W))) begin : g_bad_addr
      $error("sdw_regbank: address space too small for slot pages");
   end
   if (IDX_SHADOW_BASE + SHADOW_STRIDE * NUM_SLOTS > IDX_IRQ) begin : g_bad_win
      $error("sdw_regbank: wrapper window too small");
   end

   sdw_dec_t         dec;
   logic [IDX_W-1:0] word;
   logic             wr_wrap;
   logic             shadow_hit;
   logic             irq_hit;
   logic             gp_we;
   logic [31:0]      gp_wdata;
   logic [31:0]      gp_rd;
   logic [NUM_SLOTS-1:0] irq_stat;
   logic [63:0]      cap_q [NUM_SLOTS];
   logic [31:0]      mc_q  [NUM_SLOTS];

   sdw_addr_dec #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
      .addr (bus_addr),
      .dec  (dec),
      .sel  (slot_sel)
   );

   assign word    = bus_addr[WIN_W-1:2];
   assign wr_wrap = bus_we && dec.in_wrap;
   assign irq_hit = (int'(word) == IDX_IRQ);

   always_comb begin
      shadow_hit = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++)
         for (int k = 0; k < SHADOW_FIELDS; k++)
            if (int'(word) == IDX_SHADOW_BASE + SHADOW_STRIDE * s + k)
               shadow_hit = 1'b1;
   end

   assign gp_we    = wr_wrap && !shadow_hit && !irq_hit;
   assign gp_wdata = (int'(word) == IDX_INFO) ? (bus_wdata & ~32'h1) : bus_wdata;

   sdw_gp_file #(.IDX_W(IDX_W), .INFO_RST(INFO_RST)) u_gp (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (gp_we),
      .idx   (word),
      .wdata (gp_wdata),
      .rd    (gp_rd)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_shadow
      localparam int BASE = IDX_SHADOW_BASE + SHADOW_STRIDE * s;
      sdw_cap_shadow #(.CAP_RST(CAP_RESET), .MC_RST(MC_RESET)) u_shadow (
         .clk   (clk),
         .rst_n (rst_n),
         .we_lo (wr_wrap && (int'(word) == BASE)),
         .we_hi (wr_wrap && (int'(word) == BASE + 1)),
         .we_mc (wr_wrap && (int'(word) == BASE + 2)),
         .wdata (bus_wdata),
         .cap   (cap_q[s]),
         .mc    (mc_q[s])
      );
   end

   sdw_irq_merge #(.N(NUM_SLOTS)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (slot_irq),
      .stat  (irq_stat),
      .any   (irq_out)
   );

   always_comb begin
      bus_rdata = 32'h0;
      if (dec.in_wrap) begin
         bus_rdata = gp_rd;
         if (irq_hit) bus_rdata = {{(32 - NUM_SLOTS){1'b0}}, irq_stat};
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (int'(word) == IDX_SHADOW_BASE + SHADOW_STRIDE * s)     bus_rdata = cap_q[s][31:0];
            if (int'(word) == IDX_SHADOW_BASE + SHADOW_STRIDE * s + 1) bus_rdata = cap_q[s][63:32];
            if (int'(word) == IDX_SHADOW_BASE + SHADOW_STRIDE * s + 2) bus_rdata = mc_q[s];
         end
      end else begin
         for (int s = 0; s < NUM_SLOTS; s++)
            if (slot_sel[s]) bus_rdata = slot_rdata[s*32 +: 32];
      end
   end

   assign slot_we    = bus_we && dec.in_slot;
   assign slot_off   = bus_addr[WIN_W-1:0];
   assign slot_wdata = bus_wdata;

endmodule

// File: rtl/sdw_regbank_chk.sv
module sdw_regbank_chk #(
   parameter int ADDR_W    = 12,
   parameter int WIN_W     = 8,
   parameter int NUM_SLOTS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [31:0]          bus_rdata,
   input logic [NUM_SLOTS-1:0] slot_irq,
   input logic                 irq_out,
   input logic [NUM_SLOTS-1:0] slot_sel,
   input logic                 slot_we
);
   localparam int PAGE_W = ADDR_W - WIN_W;

   logic [PAGE_W-1:0] page;
   assign page = bus_addr[ADDR_W-1:WIN_W];

   // R2: bit 0 of the information word never reads as 1
   p_info_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == '0) |-> (bus_rdata[0] == 1'b0));

   // R8: output follows the OR of the levels sampled one edge earlier
   p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|slot_irq) |=> irq_out);
   p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_irq == '0) |=> !irq_out);

   // R9: at most one slot page selected, write strobe only with a select
   p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_sel));
   p_we_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_sel != '0) |-> (slot_we == bus_we));

   // R10: beyond the last slot page nothing is selected and reads are 0
   p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(page) > NUM_SLOTS) |-> (slot_sel == '0 && !slot_we && bus_rdata == 32'h0));

   // R11: unaligned addresses read 0 and reach no slot
   p_unaligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (slot_sel == '0 && !slot_we && bus_rdata == 32'h0));

endmodule

bind sdw_regbank sdw_regbank_chk #(
   .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .slot_irq  (slot_irq),
   .irq_out   (irq_out),
   .slot_sel  (slot_sel),
   .slot_we   (slot_we)
);

// File: tb/tb_sdw_regbank.sv
`timescale 1ns/1ps
module tb_sdw_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  slot_irq = '0;
   logic        irq_out;
   logic [1:0]  slot_sel;
   logic        slot_we;
   logic [7:0]  slot_off;
   logic [31:0] slot_wdata;
   logic [63:0] slot_rdata;

   int total = 0;
   int bad   = 0;
   logic [31:0] v;

   always #2.5 clk = ~clk;

   assign slot_rdata = {32'hB100_0000 | {24'h0, slot_off}, 32'hA000_0000 | {24'h0, slot_off}};

   sdw_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_irq(slot_irq),
      .irq_out(irq_out), .slot_sel(slot_sel), .slot_we(slot_we),
      .slot_off(slot_off), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      rd(12'h000, v); chk("R1 info", v, 32'h0003_0000);
      rd(12'h004, v); chk("R1 debounce", v, 32'h5);
      rd(12'h008, v); chk("R1 bus", v, 32'h0);
      rd(12'h0EC, v); chk("R1 wp", v, 32'h0);
      rd(12'h0F0, v); chk("R1 cd", v, 32'h0);
      rd(12'h0FC, v); chk("R1 irqstat", v, 32'h0);
      chk("R1 irq_out", {31'h0, irq_out}, 32'h0);
   endtask

   task automatic t_info();
      wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, v); chk("R2 all ones", v, 32'hFFFF_FFFE);
      wr(12'h000, 32'h0000_0001); rd(12'h000, v); chk("R2 only bit0", v, 32'h0);
   endtask

   task automatic t_plain();
      wr(12'h008, 32'h1234_ABCD); wr(12'h0EC, 32'h0000_0003);
      wr(12'h0F0, 32'h8000_0001); wr(12'h040, 32'h5A5A_A5A5);
      rd(12'h008, v); chk("R3 bus", v, 32'h1234_ABCD);
      rd(12'h0EC, v); chk("R3 wp", v, 32'h3);
      rd(12'h0F0, v); chk("R3 cd", v, 32'h8000_0001);
      rd(12'h040, v); chk("R3 spare", v, 32'h5A5A_A5A5);
   endtask

   task automatic t_cap();
      rd(12'h010, v); chk("R4 s0 lo", v, 32'h01F8_0080);
      rd(12'h014, v); chk("R4 s0 hi", v, 32'h7);
      rd(12'h020, v); chk("R4 s1 lo", v, 32'h01F8_0080);
      rd(12'h024, v); chk("R4 s1 hi", v, 32'h7);
      wr(12'h010, 32'hDEAD_BEEF);
      rd(12'h010, v); chk("R5 s0 lo new", v, 32'hDEAD_BEEF);
      rd(12'h014, v); chk("R5 s0 hi kept", v, 32'h7);
      wr(12'h024, 32'h1234_5678);
      rd(12'h024, v); chk("R5 s1 hi new", v, 32'h1234_5678);
      rd(12'h020, v); chk("R5 s1 lo kept", v, 32'h01F8_0080);
      rd(12'h014, v); chk("R5 s0 hi other slot", v, 32'h7);
   endtask

   task automatic t_maxcur();
      rd(12'h018, v); chk("R6 s0 reset", v, 32'h0);
      rd(12'h028, v); chk("R6 s1 reset", v, 32'h0);
      wr(12'h028, 32'h0000_CAFE);
      rd(12'h028, v); chk("R6 s1 new", v, 32'h0000_CAFE);
      rd(12'h018, v); chk("R6 s0 untouched", v, 32'h0);
      wr(12'h018, 32'h0000_1111);
      rd(12'h028, v); chk("R6 s1 kept", v, 32'h0000_CAFE);
   endtask

   task automatic t_irq();
      @(negedge clk) slot_irq = 2'b10;
      rd(12'h0FC, v); chk("R7 slot1 up", v, 32'h2);
      chk("R8 out slot1", {31'h0, irq_out}, 32'h1);
      @(negedge clk) slot_irq = 2'b11;
      rd(12'h0FC, v); chk("R7 both up", v, 32'h3);
      @(negedge clk) slot_irq = 2'b01;
      rd(12'h0FC, v); chk("R7 slot1 down", v, 32'h1);
      chk("R8 out kept by slot0", {31'h0, irq_out}, 32'h1);
      wr(12'h0FC, 32'hFFFF_FFFF);
      rd(12'h0FC, v); chk("R7 write ignored", v, 32'h1);
      @(negedge clk) slot_irq = 2'b00;
      rd(12'h0FC, v); chk("R7 all down", v, 32'h0);
      chk("R8 out low", {31'h0, irq_out}, 32'h0);
   endtask

   task automatic t_slotwin();
      rd(12'h1A4, v); chk("R9 s0 rdata", v, 32'hA000_00A4);
      chk("R9 s0 sel", {30'h0, slot_sel}, 32'h1);
      chk("R9 s0 off", {24'h0, slot_off}, 32'hA4);
      rd(12'h2F0, v); chk("R9 s1 rdata", v, 32'hB100_00F0);
      chk("R9 s1 sel", {30'h0, slot_sel}, 32'h2);
      @(negedge clk);
      bus_addr = 12'h108; bus_wdata = 32'h0000_0055; bus_we = 1'b1;
      #1;
      chk("R9 slot_we", {31'h0, slot_we}, 32'h1);
      chk("R9 slot_wdata", slot_wdata, 32'h55);
      @(negedge clk) bus_we = 1'b0;
      rd(12'h008, v); chk("R9 wrapper untouched", v, 32'h1234_ABCD);
   endtask

   task automatic t_range();
      wr(12'h308, 32'h0000_0099);
      rd(12'h308, v); chk("R10 read zero", v, 32'h0);
      chk("R10 no sel", {30'h0, slot_sel}, 32'h0);
      rd(12'h008, v); chk("R10 wrapper untouched", v, 32'h1234_ABCD);
      rd(12'hFFC, v); chk("R10 top read zero", v, 32'h0);
   endtask

   task automatic t_unaligned();
      wr(12'h00A, 32'h0000_0077);
      rd(12'h008, v); chk("R11 wrapper untouched", v, 32'h1234_ABCD);
      rd(12'h00A, v); chk("R11 read zero", v, 32'h0);
      rd(12'h101, v); chk("R11 slot read zero", v, 32'h0);
      chk("R11 no sel", {30'h0, slot_sel}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_info();
      t_plain();
      t_cap();
      t_maxcur();
      t_irq();
      t_slotwin();
      t_range();
      t_unaligned();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule